// File: doc/BRIEF.md
# Indexed Load Address and Extension Unit

This unit carries out the data-side work of one load instruction in a small 32-bit core. It receives an operation already decoded: the base register value, a 13-bit signed immediate, an indexing mode, a load kind, and the numbers of the destination and base registers. From these it forms the access address and, for the indexed modes, the updated base value. It then issues word-wide memory reads, picks the addressed byte or halfword lane out of the returned data, extends it to 32 bits, and hands the result back with its destination register number.

A register-pair load uses two consecutive memory beats and returns one result per beat. A word load whose destination is the program counter is treated as a branch. The unit checks the loaded target and reports which instruction state execution continues in. Register-number conflicts that would make a base update ambiguous are reported as faults before any memory traffic starts. Memory uses a hold-until-served handshake: `mem_req` stays high with a stable address until `mem_rvalid` is seen on a clock edge.

Top module: `ldx_unit`

## Requirements
- R1: Offset mode (`req_mode` 0, and the unused code 3) reads at base + sign-extended offset and never asserts `wb_en`.
- R2: Pre-indexed mode (`req_mode` 1) reads at base + offset. At `done` it asserts `wb_en` with `wb_data` equal to that same sum and `wb_reg` equal to `req_rn`.
- R3: Post-indexed mode (`req_mode` 2) reads at the unmodified base. At `done` it writes back base + offset to `req_rn`.
- R4: `req_offset` is a 13-bit two's-complement value (-4096 to 4095). Address and writeback sums wrap modulo 2^32.
- R5: Byte loads take byte lane `addr[1:0]` of the read data, with lane 0 in bits 7:0. Kind 1 zero-extends the byte and kind 2 sign-extends it.
- R6: Halfword loads take the half selected by `addr[1]`, with half 0 in bits 15:0. Kind 3 zero-extends it and kind 4 sign-extends it.
- R7: Word loads (kind 0) return the 32-bit read data unchanged, whatever the low address bits.
- R8: A pair load (kind 5) reads at the computed address and then at that address + 4. It returns results to `req_rt` and then to `req_rt`+1. It pulses `done` only with the second result, and its writeback applies the offset once.
- R9: In the indexed modes, a destination equal to the base register (for pair loads, either destination) raises `fault` with `fault_code` 1. It then makes no memory access, no writeback and no `done`. In offset mode the same register numbers are accepted.
- R10: A pair load with an odd `req_rt` raises `fault` with `fault_code` 2 and makes no memory access.
- R11: A word load into register 15 that completes pulses `br_take` with `done`, and `br_state` equals bit 0 of the loaded target. Non-word loads into register 15 never branch.
- R12: A branch target whose low two bits are binary 10 gives `done` together with `fault` and `fault_code` 3. In that case `br_take` is low and `wb_en` is suppressed.
- R13: After reset `req_ready` is high and `mem_req`, `res_valid`, `done`, `wb_en`, `br_take` and `fault` are low. `req_ready` stays low while a load is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Load operation offered |
| req_ready | output | 1 | Unit idle, offer accepted this edge |
| req_kind | input | 3 | 0 word, 1 ubyte, 2 sbyte, 3 uhalf, 4 shalf, 5 pair |
| req_mode | input | 2 | 0 offset, 1 pre-indexed, 2 post-indexed |
| req_base | input | 32 | Base register value |
| req_offset | input | 13 | Signed immediate offset |
| req_rt | input | 4 | First destination register number |
| req_rn | input | 4 | Base register number |
| mem_req | output | 1 | Read request, held until served |
| mem_addr | output | 32 | Read address |
| mem_rvalid | input | 1 | Read data valid, completes the beat |
| mem_rdata | input | 32 | Read data |
| res_valid | output | 1 | Result beat valid |
| res_dest | output | 4 | Destination register of the result |
| res_data | output | 32 | Extended result |
| done | output | 1 | Final beat of the operation |
| wb_en | output | 1 | Base writeback strobe |
| wb_reg | output | 4 | Base register to update |
| wb_data | output | 32 | Updated base value |
| br_take | output | 1 | Load into program counter taken as branch |
| br_state | output | 1 | Instruction state to continue in (1 compressed) |
| fault | output | 1 | Fault pulse |
| fault_code | output | 2 | 1 base clash, 2 odd pair, 3 illegal target |

## Verification
Each indexing mode is applied with bases and offsets that make the three address and writeback outcomes differ, so swapping mode behaviour shows up at once. Negative offsets and sums that cross zero or the top of the address space expose a missing sign extension or a truncated adder. The read data is chosen with opposite sign bits in neighbouring lanes, so a wrong lane, byte order or extension kind gives a different value. Pair loads, register conflicts, odd pairs and program-counter targets ending in 00, 01 and 10 separate the sequencing, fault priority and branch-state paths.

// File: rtl/ldx_pkg.sv
package ldx_pkg;

    localparam int XLEN   = 32;
    localparam int REGW   = 4;
    localparam int PC_IDX = 15;

    typedef enum logic [1:0] {
        IDX_OFFSET = 2'd0,
        IDX_PRE    = 2'd1,
        IDX_POST   = 2'd2,
        IDX_RSVD   = 2'd3
    } idx_mode_e;

    typedef enum logic [2:0] {
        LK_WORD  = 3'd0,
        LK_UBYTE = 3'd1,
        LK_SBYTE = 3'd2,
        LK_UHALF = 3'd3,
        LK_SHALF = 3'd4,
        LK_PAIR  = 3'd5
    } ld_kind_e;

    typedef enum logic [1:0] {
        FLT_NONE       = 2'd0,
        FLT_BASE_CLASH = 2'd1,
        FLT_ODD_PAIR   = 2'd2,
        FLT_BAD_TARGET = 2'd3
    } flt_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_BEAT0 = 2'd1,
        ST_BEAT1 = 2'd2
    } seq_e;

    typedef struct packed {
        ld_kind_e        kind;
        logic [REGW-1:0] rt;
        logic [REGW-1:0] rn;
        logic [XLEN-1:0] addr;
        logic [XLEN-1:0] wb_val;
        logic            wb_req;
    } ld_op_t;

    function automatic logic is_indexed(idx_mode_e m);
        return (m == IDX_PRE) || (m == IDX_POST);
    endfunction

    function automatic logic target_illegal(logic [XLEN-1:0] t);
        return t[1:0] == 2'b10;
    endfunction

endpackage

// File: rtl/ldx_agu.sv
module ldx_agu
    import ldx_pkg::*;
#(
    parameter int OFFW = 13
) (
    input  logic [XLEN-1:0] base,
    input  logic [OFFW-1:0] offset,
    input  idx_mode_e       mode,
    output logic [XLEN-1:0] addr,
    output logic [XLEN-1:0] wb_val,
    output logic            wb_req
);
    localparam int EXTW = XLEN - OFFW;

    logic [XLEN-1:0] off_ext;
    logic [XLEN-1:0] sum;

    always_comb begin
        off_ext = {{EXTW{offset[OFFW-1]}}, offset};
        sum     = base + off_ext;
        wb_val  = sum;
        wb_req  = is_indexed(mode);
        addr    = (mode == IDX_POST) ? base : sum;
    end
endmodule

// File: rtl/ldx_hazard.sv
module ldx_hazard
    import ldx_pkg::*;
(
    input  ld_kind_e        kind,
    input  idx_mode_e       mode,
    input  logic [REGW-1:0] rt,
    input  logic [REGW-1:0] rn,
    output flt_e            flt
);
    logic [REGW-1:0] rt_hi;
    logic            pair;

    always_comb begin
        pair  = (kind == LK_PAIR);
        rt_hi = rt | {{(REGW-1){1'b0}}, 1'b1};
        flt   = FLT_NONE;
        if (pair && rt[0]) begin
            flt = FLT_ODD_PAIR;
        end else if (is_indexed(mode)) begin
            if (rn == rt || (pair && rn == rt_hi)) begin
                flt = FLT_BASE_CLASH;
            end
        end
    end
endmodule

// File: rtl/ldx_ext.sv
module ldx_ext
    import ldx_pkg::*;
#(
    localparam int NBYTE = XLEN / 8,
    localparam int NHALF = XLEN / 16,
    localparam int LW    = $clog2(NBYTE)
) (
    input  ld_kind_e        kind,
    input  logic [LW-1:0]   lane,
    input  logic [XLEN-1:0] data,
    output logic [XLEN-1:0] result
);
    logic [7:0]  byte_of [NBYTE];
    logic [15:0] half_of [NHALF];

    genvar gi;
    generate
        for (gi = 0; gi < NBYTE; gi++) begin : g_byte
            assign byte_of[gi] = data[8*gi +: 8];
        end
        for (gi = 0; gi < NHALF; gi++) begin : g_half
            assign half_of[gi] = data[16*gi +: 16];
        end
    endgenerate

    logic [7:0]  b_sel;
    logic [15:0] h_sel;

    always_comb begin
        b_sel = byte_of[lane];
        h_sel = half_of[lane[LW-1:1]];
        unique case (kind)
            LK_UBYTE: result = {{(XLEN-8){1'b0}}, b_sel};
            LK_SBYTE: result = {{(XLEN-8){b_sel[7]}}, b_sel};
            LK_UHALF: result = {{(XLEN-16){1'b0}}, h_sel};
            LK_SHALF: result = {{(XLEN-16){h_sel[15]}}, h_sel};
            default:  result = data;
        endcase
    end
endmodule

// File: rtl/ldx_unit.sv
module ldx_unit
    import ldx_pkg::*;
#(
    parameter int OFFW = 13
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            req_valid,
    output logic            req_ready,
    input  logic [2:0]      req_kind,
    input  logic [1:0]      req_mode,
    input  logic [31:0]     req_base,
    input  logic [OFFW-1:0] req_offset,
    input  logic [3:0]      req_rt,
    input  logic [3:0]      req_rn,
    output logic            mem_req,
    output logic [31:0]     mem_addr,
    input  logic            mem_rvalid,
    input  logic [31:0]     mem_rdata,
    output logic            res_valid,
    output logic [3:0]      res_dest,
    output logic [31:0]     res_data,
    output logic            done,
    output logic            wb_en,
    output logic [3:0]      wb_reg,
    output logic [31:0]     wb_data,
    output logic            br_take,
    output logic            br_state,
    output logic            fault,
    output logic [1:0]      fault_code
);
    localparam int LW = $clog2(XLEN / 8);
    localparam logic [REGW-1:0] PC_NUM = REGW'(PC_IDX);
    localparam logic [XLEN-1:0] WORD_STEP = XLEN'(XLEN / 8);

    ld_kind_e  in_kind;
    idx_mode_e in_mode;
    assign in_kind = ld_kind_e'(req_kind);
    assign in_mode = idx_mode_e'(req_mode);

    logic [XLEN-1:0] agu_addr, agu_wb;
    logic            agu_wbreq;
    flt_e            in_flt;

    ldx_agu #(.OFFW(OFFW)) i_agu (
        .base   (req_base),
        .offset (req_offset),
        .mode   (in_mode),
        .addr   (agu_addr),
        .wb_val (agu_wb),
        .wb_req (agu_wbreq)
    );

    ldx_hazard i_hazard (
        .kind (in_kind),
        .mode (in_mode),
        .rt   (req_rt),
        .rn   (req_rn),
        .flt  (in_flt)
    );

    seq_e   state;
    ld_op_t op;

    logic [XLEN-1:0] ext_data;
    ldx_ext i_ext (
        .kind   (op.kind),
        .lane   (op.addr[LW-1:0]),
        .data   (mem_rdata),
        .result (ext_data)
    );

    logic accept, beat_done, last_beat, is_branch, bad_tgt;

    always_comb begin
        req_ready = (state == ST_IDLE);
        accept    = req_valid && req_ready;
        mem_req   = (state == ST_BEAT0) || (state == ST_BEAT1);
        mem_addr  = op.addr;
        beat_done = mem_req && mem_rvalid;
        last_beat = (state == ST_BEAT1) || (op.kind != LK_PAIR);
        is_branch = (op.kind == LK_WORD) && (op.rt == PC_NUM);
        bad_tgt   = is_branch && target_illegal(mem_rdata);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= ST_IDLE;
            op         <= '0;
            res_valid  <= 1'b0;
            res_dest   <= '0;
            res_data   <= '0;
            done       <= 1'b0;
            wb_en      <= 1'b0;
            wb_reg     <= '0;
            wb_data    <= '0;
            br_take    <= 1'b0;
            br_state   <= 1'b0;
            fault      <= 1'b0;
            fault_code <= FLT_NONE;
        end else begin
            res_valid <= 1'b0;
            done      <= 1'b0;
            wb_en     <= 1'b0;
            br_take   <= 1'b0;
            fault     <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (accept) begin
                        if (in_flt != FLT_NONE) begin
                            fault      <= 1'b1;
                            fault_code <= in_flt;
                        end else begin
                            op.kind   <= in_kind;
                            op.rt     <= req_rt;
                            op.rn     <= req_rn;
                            op.addr   <= agu_addr;
                            op.wb_val <= agu_wb;
                            op.wb_req <= agu_wbreq;
                            state     <= ST_BEAT0;
                        end
                    end
                end
                ST_BEAT0, ST_BEAT1: begin
                    if (beat_done) begin
                        res_valid <= 1'b1;
                        res_data  <= ext_data;
                        res_dest  <= (state == ST_BEAT1) ? (op.rt | 4'd1) : op.rt;
                        if (last_beat) begin
                            state   <= ST_IDLE;
                            done    <= 1'b1;
                            wb_reg  <= op.rn;
                            wb_data <= op.wb_val;
                            wb_en   <= op.wb_req && !bad_tgt;
                            if (bad_tgt) begin
                                fault      <= 1'b1;
                                fault_code <= FLT_BAD_TARGET;
                            end else if (is_branch) begin
                                br_take  <= 1'b1;
                                br_state <= mem_rdata[0];
                            end
                        end else begin
                            state   <= ST_BEAT1;
                            op.addr <= op.addr + WORD_STEP;
                        end
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/ldx_unit_chk.sv
module ldx_unit_chk (
    input logic        clk,
    input logic        rst,
    input logic        req_ready,
    input logic        mem_req,
    input logic [31:0] mem_addr,
    input logic        mem_rvalid,
    input logic        res_valid,
    input logic        done,
    input logic        wb_en,
    input logic        br_take,
    input logic        fault,
    input logic [1:0]  fault_code
);
    p_req_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_rvalid) |=> (mem_req && $stable(mem_addr)));

    p_pair_step_r8: assert property (@(posedge clk) disable iff (rst)
        (mem_req && mem_rvalid) |=> (!mem_req || mem_addr == $past(mem_addr) + 32'd4));

    p_busy_r13: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> !req_ready);

    p_wb_with_done_r2: assert property (@(posedge clk) disable iff (rst)
        wb_en |-> done);

    p_clash_quiet_r9: assert property (@(posedge clk) disable iff (rst)
        (fault && fault_code != 2'd3) |-> (!done && !wb_en && !res_valid && !mem_req));

    p_bad_target_r12: assert property (@(posedge clk) disable iff (rst)
        (fault && fault_code == 2'd3) |-> (done && !wb_en && !br_take));

    p_branch_r11: assert property (@(posedge clk) disable iff (rst)
        br_take |-> (done && res_valid && !fault));
endmodule

bind ldx_unit ldx_unit_chk i_ldx_unit_chk (
    .clk        (clk),
    .rst        (rst),
    .req_ready  (req_ready),
    .mem_req    (mem_req),
    .mem_addr   (mem_addr),
    .mem_rvalid (mem_rvalid),
    .res_valid  (res_valid),
    .done       (done),
    .wb_en      (wb_en),
    .br_take    (br_take),
    .fault      (fault),
    .fault_code (fault_code)
);

// File: tb/test_ldx_unit.sv
module test_ldx_unit;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [2:0]  req_kind = '0;
    logic [1:0]  req_mode = '0;
    logic [31:0] req_base = '0;
    logic [12:0] req_offset = '0;
    logic [3:0]  req_rt = '0;
    logic [3:0]  req_rn = '0;
    logic        mem_req;
    logic [31:0] mem_addr;
    logic        mem_rvalid = 1'b0;
    logic [31:0] mem_rdata = '0;
    logic        res_valid;
    logic [3:0]  res_dest;
    logic [31:0] res_data;
    logic        done;
    logic        wb_en;
    logic [3:0]  wb_reg;
    logic [31:0] wb_data;
    logic        br_take;
    logic        br_state;
    logic        fault;
    logic [1:0]  fault_code;

    always #5 clk = ~clk;

    ldx_unit i_ldx_unit (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_kind(req_kind), .req_mode(req_mode), .req_base(req_base),
        .req_offset(req_offset), .req_rt(req_rt), .req_rn(req_rn),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_rvalid(mem_rvalid),
        .mem_rdata(mem_rdata), .res_valid(res_valid), .res_dest(res_dest),
        .res_data(res_data), .done(done), .wb_en(wb_en), .wb_reg(wb_reg),
        .wb_data(wb_data), .br_take(br_take), .br_state(br_state),
        .fault(fault), .fault_code(fault_code)
    );

    int n_vec = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    logic [31:0] dat0, dat1;
    int          resp_n;
    logic [31:0] addr_log [2];
    int          n_res, n_done, n_flt;
    logic [31:0] got_data [2];
    logic [3:0]  got_dest [2];
    logic        got_wbe, got_br, got_brs;
    logic [31:0] got_wbd;
    logic [3:0]  got_wbr;
    logic [1:0]  got_fc;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // memory responder: serves a held request every other cycle
    initial begin
        forever begin
            @(negedge clk);
            begin
                logic prev;
                prev = mem_rvalid;
                mem_rvalid = 1'b0;
                if (mem_req && !prev) begin
                    mem_rvalid = 1'b1;
                    mem_rdata  = (resp_n == 0) ? dat0 : dat1;
                    if (resp_n < 2) addr_log[resp_n] = mem_addr;
                    resp_n++;
                end
            end
        end
    end

    task automatic run_load(input logic [2:0] kind, input logic [1:0] mode,
                            input logic [31:0] base, input logic [12:0] off,
                            input logic [3:0] rt, input logic [3:0] rn,
                            input logic [31:0] d0, input logic [31:0] d1);
        @(negedge clk);
        dat0 = d0; dat1 = d1; resp_n = 0;
        addr_log[0] = '0; addr_log[1] = '0;
        n_res = 0; n_done = 0; n_flt = 0;
        got_wbe = 0; got_br = 0; got_brs = 0; got_wbd = '0; got_wbr = '0; got_fc = '0;
        got_data[0] = '0; got_data[1] = '0; got_dest[0] = '0; got_dest[1] = '0;
        req_kind = kind; req_mode = mode; req_base = base; req_offset = off;
        req_rt = rt; req_rn = rn; req_valid = 1'b1;
        for (int c = 0; c < 14; c++) begin
            @(negedge clk);
            req_valid = 1'b0;
            if (res_valid) begin
                if (n_res < 2) begin
                    got_data[n_res] = res_data;
                    got_dest[n_res] = res_dest;
                end
                n_res++;
            end
            if (done) begin
                n_done++;
                got_wbe = wb_en; got_wbd = wb_data; got_wbr = wb_reg;
            end
            if (br_take) begin got_br = 1'b1; got_brs = br_state; end
            if (fault) begin n_flt++; got_fc = fault_code; end
        end
    endtask

    task automatic t_reset;
        check("R13 ready", {31'b0, req_ready}, 32'd1);
        check("R13 quiet", {26'b0, mem_req, res_valid, done, wb_en, br_take, fault}, 32'd0);
    endtask

    task automatic t_offset;
        run_load(3'd0, 2'd0, 32'h0000_1002, 13'd1, 4'd1, 4'd2, 32'hCAFE_8001, 32'h0);
        check("R1 addr", addr_log[0], 32'h0000_1003);
        check("R1 no wb", {31'b0, got_wbe}, 32'd0);
        check("R7 word data", got_data[0], 32'hCAFE_8001);
        check("R7 done", n_done, 1);
        run_load(3'd0, 2'd3, 32'h0000_0100, 13'h1FFC, 4'd1, 4'd2, 32'h1, 32'h0);
        check("R1 mode3 addr", addr_log[0], 32'h0000_00FC);
        check("R1 mode3 no wb", {31'b0, got_wbe}, 32'd0);
    endtask

    task automatic t_pre;
        run_load(3'd1, 2'd1, 32'h0000_2000, 13'd5, 4'd3, 4'd6, 32'h11F2_8344, 32'h0);
        check("R2 addr", addr_log[0], 32'h0000_2005);
        check("R2 wb_en", {31'b0, got_wbe}, 32'd1);
        check("R2 wb_data", got_wbd, 32'h0000_2005);
        check("R2 wb_reg", {28'b0, got_wbr}, 32'd6);
        check("R5 ubyte lane1", got_data[0], 32'h0000_0083);
    endtask

    task automatic t_post;
        run_load(3'd2, 2'd2, 32'h0000_3003, 13'h1FF0, 4'd3, 4'd6, 32'h9A34_5678, 32'h0);
        check("R3 addr", addr_log[0], 32'h0000_3003);
        check("R3 wb_data", got_wbd, 32'h0000_2FF3);
        check("R3 wb_en", {31'b0, got_wbe}, 32'd1);
        check("R5 sbyte lane3", got_data[0], 32'hFFFF_FF9A);
        run_load(3'd2, 2'd0, 32'h0000_4002, 13'd0, 4'd3, 4'd6, 32'h9A34_5678, 32'h0);
        check("R5 sbyte lane2 positive", got_data[0], 32'h0000_0034);
    endtask

    task automatic t_wrap;
        run_load(3'd0, 2'd1, 32'hFFFF_FFF0, 13'h0020, 4'd1, 4'd2, 32'h5, 32'h0);
        check("R4 wrap up addr", addr_log[0], 32'h0000_0010);
        check("R4 wrap up wb", got_wbd, 32'h0000_0010);
        run_load(3'd0, 2'd0, 32'h0000_0008, 13'h1000, 4'd1, 4'd2, 32'h5, 32'h0);
        check("R4 wrap down addr", addr_log[0], 32'hFFFF_F008);
    endtask

    task automatic t_half;
        run_load(3'd3, 2'd0, 32'h0000_5002, 13'd0, 4'd1, 4'd2, 32'h8001_7FFF, 32'h0);
        check("R6 uhalf upper", got_data[0], 32'h0000_8001);
        run_load(3'd4, 2'd0, 32'h0000_5002, 13'd0, 4'd1, 4'd2, 32'h8001_7FFF, 32'h0);
        check("R6 shalf upper", got_data[0], 32'hFFFF_8001);
        run_load(3'd4, 2'd0, 32'h0000_5000, 13'd0, 4'd1, 4'd2, 32'h8001_7FFF, 32'h0);
        check("R6 shalf lower", got_data[0], 32'h0000_7FFF);
    endtask

    task automatic t_pair;
        run_load(3'd5, 2'd1, 32'h0000_4000, 13'd8, 4'd2, 4'd7, 32'hAAAA_0001, 32'hBBBB_0002);
        check("R8 beats", resp_n, 2);
        check("R8 addr0", addr_log[0], 32'h0000_4008);
        check("R8 addr1", addr_log[1], 32'h0000_400C);
        check("R8 results", n_res, 2);
        check("R8 data0", got_data[0], 32'hAAAA_0001);
        check("R8 data1", got_data[1], 32'hBBBB_0002);
        check("R8 dest0", {28'b0, got_dest[0]}, 32'd2);
        check("R8 dest1", {28'b0, got_dest[1]}, 32'd3);
        check("R8 one done", n_done, 1);
        check("R8 wb once", got_wbd, 32'h0000_4008);
    endtask

    task automatic t_clash;
        run_load(3'd0, 2'd1, 32'h0000_1000, 13'd4, 4'd5, 4'd5, 32'h1, 32'h0);
        check("R9 fault", n_flt, 1);
        check("R9 code", {30'b0, got_fc}, 32'd1);
        check("R9 no access", resp_n, 0);
        check("R9 no done", n_done, 0);
        run_load(3'd5, 2'd2, 32'h0000_1000, 13'd4, 4'd4, 4'd5, 32'h1, 32'h2);
        check("R9 pair high clash code", {30'b0, got_fc}, 32'd1);
        check("R9 pair no access", resp_n, 0);
        run_load(3'd0, 2'd0, 32'h0000_1000, 13'd4, 4'd5, 4'd5, 32'h77, 32'h0);
        check("R9 offset mode allowed", n_flt, 0);
        check("R9 offset mode result", got_data[0], 32'h0000_0077);
    endtask

    task automatic t_odd;
        run_load(3'd5, 2'd0, 32'h0000_1000, 13'd0, 4'd3, 4'd9, 32'h1, 32'h2);
        check("R10 fault", n_flt, 1);
        check("R10 code", {30'b0, got_fc}, 32'd2);
        check("R10 no access", resp_n, 0);
    endtask

    task automatic t_branch;
        run_load(3'd0, 2'd0, 32'h0000_6000, 13'd0, 4'd15, 4'd1, 32'h0000_8001, 32'h0);
        check("R11 take", {31'b0, got_br}, 32'd1);
        check("R11 compressed state", {31'b0, got_brs}, 32'd1);
        run_load(3'd0, 2'd0, 32'h0000_6000, 13'd0, 4'd15, 4'd1, 32'h0000_8000, 32'h0);
        check("R11 normal state", {31'b0, got_brs}, 32'd0);
        check("R11 take normal", {31'b0, got_br}, 32'd1);
        run_load(3'd1, 2'd0, 32'h0000_6000, 13'd0, 4'd15, 4'd1, 32'h0000_8001, 32'h0);
        check("R11 byte no branch", {31'b0, got_br}, 32'd0);
    endtask

    task automatic t_bad_target;
        run_load(3'd0, 2'd1, 32'h0000_7000, 13'd4, 4'd15, 4'd1, 32'h0000_8002, 32'h0);
        check("R12 fault code", {30'b0, got_fc}, 32'd3);
        check("R12 done", n_done, 1);
        check("R12 no branch", {31'b0, got_br}, 32'd0);
        check("R12 no wb", {31'b0, got_wbe}, 32'd0);
    endtask

    initial begin
        #(200000 * 10);
        if (!finished) begin
            n_vec++; n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        resp_n = 0; dat0 = '0; dat1 = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_offset();
        t_pre();
        t_post();
        t_wrap();
        t_half();
        t_pair();
        t_clash();
        t_odd();
        t_branch();
        t_bad_target();
        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule